// File: doc/BRIEF.md
# Programmable Duty Pulse Channel

This block produces one square-wave voice for a cartridge's extra sound hardware. It advances once for each CPU cycle on which `tickEn` is high. A 12-bit period counter sets how often a 16-step sequencer moves forward. A 3-bit duty threshold then decides, for each step, whether the 4-bit volume or silence appears at the output. A constant-level mode ignores the duty threshold and holds the volume whenever the sequencer moves.

Software programs the channel through three write strobes that share one 8-bit data bus:

- The control strobe loads the shape fields.
- Two period strobes load the low and high parts of the period.
- The high period strobe also carries the channel enable.

The 4-bit sample goes to a mixer outside this block.

Top module: `pulse_tone_gen`

## Requirements
- R1: A write on `wrCtrl` loads three fields from `wrData`: the constant-level flag from bit 7, the duty threshold from bits 6..4, and the volume from bits 3..0.
- R2: A write on `wrPerLo` loads period bits 7..0 from `wrData[7:0]`. A write on `wrPerHi` loads period bits 11..8 from `wrData[3:0]` and the channel enable from `wrData[7]`. Bits 6..4 of a `wrPerHi` write are ignored.
- R3: The divider counts down by one on each cycle with `tickEn` high. On a tick where it holds 1, it reloads with period+1 and the 4-bit step counter advances by one, wrapping from 15 to 0. With period 0 the step advances on every tick, and with period 0xFFF it advances every 4096 ticks without overflow.
- R4: On a tick that advances the step, the output takes the volume if the constant-level flag is 1 or the new step value is greater than the duty threshold. Otherwise the output becomes 0. Between advances the output holds its value.
- R5: On every tick where the enable is 0, the output becomes 0.
- R6: On a cycle with `tickEn` low, the divider, step counter and output do not change. Register writes still take effect on such a cycle.
- R7: A synchronous active-high `rst` sets the divider to 1 and clears the step counter, the output and every register field.
- R8: A register write never reloads the divider. A tick in the same cycle as a write uses the old register values, and a new period first takes effect at the next divider reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Clock enable: one CPU cycle |
| wrCtrl | input | 1 | Write strobe for the shape fields |
| wrPerLo | input | 1 | Write strobe for the low period bits |
| wrPerHi | input | 1 | Write strobe for the high period bits and the enable |
| wrData | input | 8 | Write data |
| sampleOut | output | 4 | Current sample level |

## Verification
The assertions assume that `rst` is held high at time zero and that the three write strobes are single-cycle pulses sampled on the clock edge. They also assume the strobes may arrive in any combination with `tickEn`, including all in the same cycle. The stimulus drives every input on the falling edge, so each write and each tick lands cleanly on one rising edge. The stimulus covers:

- bursts of ticks,
- ticks with gaps,
- writes that coincide with a divider reload,
- long randomised sequences.

No combination of inputs is excluded, because the block must accept any of them.

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic tick;     // enabled cycle
    logic advance;  // divider expires on this tick
    logic gateOn;   // channel enable as held before the edge
  } toneStrobe_t;

endpackage

// File: rtl/pulse_tone_ctrl.sv
module pulse_tone_ctrl
  import pulse_tone_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 12,
  parameter int DUTY_W   = 3,
  parameter int VOL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickEn,
  input  logic                wrCtrl,
  input  logic                wrPerLo,
  input  logic                wrPerHi,
  input  logic [DATA_W-1:0]   wrData,
  output logic                modeBit,
  output logic [DUTY_W-1:0]   dutyVal,
  output logic [VOL_W-1:0]    volVal,
  output logic                enBit,
  output logic [PERIOD_W-1:0] periodVal,
  output logic [PERIOD_W:0]   divCount,
  output toneStrobe_t         strobes
);

  localparam int DIV_W    = PERIOD_W + 1;
  localparam int HI_W     = PERIOD_W - DATA_W;
  localparam int MODE_BIT = DATA_W - 1;
  localparam int EN_BIT   = DATA_W - 1;
  localparam int DUTY_LSB = VOL_W;

  logic [DIV_W-1:0] reloadVal;
  logic             expire;

  // Register fields
  always_ff @(posedge clk) begin
    if (rst) begin
      modeBit   <= 1'b0;
      dutyVal   <= '0;
      volVal    <= '0;
      enBit     <= 1'b0;
      periodVal <= '0;
    end else begin
      if (wrCtrl) begin
        modeBit <= wrData[MODE_BIT];
        dutyVal <= wrData[DUTY_LSB +: DUTY_W];
        volVal  <= wrData[VOL_W-1:0];
      end
      if (wrPerLo) begin
        periodVal[DATA_W-1:0] <= wrData;
      end
      if (wrPerHi) begin
        periodVal[PERIOD_W-1:DATA_W] <= wrData[HI_W-1:0];
        enBit <= wrData[EN_BIT];
      end
    end
  end

  // Period divider: one wider than the period so period+1 fits
  assign reloadVal = DIV_W'(periodVal) + DIV_W'(1);
  assign expire    = (divCount == DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      divCount <= DIV_W'(1);
    end else if (tickEn) begin
      if (expire) divCount <= reloadVal;
      else        divCount <= divCount - DIV_W'(1);
    end
  end

  always_comb begin
    strobes.tick    = tickEn;
    strobes.advance = tickEn & expire;
    strobes.gateOn  = enBit;
  end

endmodule

// File: rtl/pulse_tone_dp.sv
module pulse_tone_dp
  import pulse_tone_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int DUTY_W = 3,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  toneStrobe_t       strobes,
  input  logic              modeBit,
  input  logic [DUTY_W-1:0] dutyVal,
  input  logic [VOL_W-1:0]  volVal,
  output logic [STEP_W-1:0] stepCount,
  output logic [VOL_W-1:0]  sampleOut
);

  logic [STEP_W-1:0] stepNext;
  logic              passHigh;
  logic [VOL_W-1:0]  levelNext;

  assign stepNext  = stepCount + STEP_W'(1);
  assign passHigh  = modeBit | (stepNext > STEP_W'(dutyVal));
  assign levelNext = passHigh ? volVal : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCount <= '0;
    end else if (strobes.advance) begin
      stepCount <= stepNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut <= '0;
    end else if (strobes.tick) begin
      if (!strobes.gateOn)      sampleOut <= '0;
      else if (strobes.advance) sampleOut <= levelNext;
    end
  end

endmodule

// File: rtl/pulse_tone_gen.sv
module pulse_tone_gen
  import pulse_tone_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 12,
  parameter int STEP_W   = 4,
  parameter int DUTY_W   = 3,
  parameter int VOL_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              wrCtrl,
  input  logic              wrPerLo,
  input  logic              wrPerHi,
  input  logic [DATA_W-1:0] wrData,
  output logic [VOL_W-1:0]  sampleOut
);

  toneStrobe_t         strobes;
  logic                modeBit;
  logic [DUTY_W-1:0]   dutyVal;
  logic [VOL_W-1:0]    volVal;
  logic                enBit;
  logic [PERIOD_W-1:0] periodVal;
  logic [PERIOD_W:0]   divCount;
  logic [STEP_W-1:0]   stepCount;

  pulse_tone_ctrl #(
    .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .wrCtrl(wrCtrl), .wrPerLo(wrPerLo), .wrPerHi(wrPerHi), .wrData(wrData),
    .modeBit(modeBit), .dutyVal(dutyVal), .volVal(volVal), .enBit(enBit),
    .periodVal(periodVal), .divCount(divCount), .strobes(strobes)
  );

  pulse_tone_dp #(
    .STEP_W(STEP_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W)
  ) uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .modeBit(modeBit), .dutyVal(dutyVal), .volVal(volVal),
    .stepCount(stepCount), .sampleOut(sampleOut)
  );

endmodule

// File: rtl/pulse_tone_chk.sv
module pulse_tone_chk #(
  parameter int PERIOD_W = 12,
  parameter int STEP_W   = 4,
  parameter int VOL_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tickEn,
  input logic                enBit,
  input logic [PERIOD_W-1:0] periodVal,
  input logic [PERIOD_W:0]   divCount,
  input logic [STEP_W-1:0]   stepCount,
  input logic [VOL_W-1:0]    sampleOut
);

  localparam int DIV_W = PERIOD_W + 1;

  // R7: reset state
  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (divCount == DIV_W'(1) && stepCount == '0 && sampleOut == '0));

  // R3: divider never sits at zero
  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    divCount != '0);

  // R3: expiry advances the step by one
  p_step_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (tickEn && divCount == DIV_W'(1)) |=> stepCount == STEP_W'($past(stepCount) + 1'b1));

  // R3: no expiry, no step movement
  p_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(tickEn && divCount == DIV_W'(1)) |=> $stable(stepCount));

  // R8: reload uses the period held before the edge
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (tickEn && divCount == DIV_W'(1)) |=> divCount == DIV_W'($past(periodVal)) + DIV_W'(1));

  // R5: disabled channel is silent after a tick
  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    (tickEn && !enBit) |=> sampleOut == '0);

  // R6: idle cycles freeze divider and output
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> ($stable(sampleOut) && $stable(divCount)));

endmodule

bind pulse_tone_gen pulse_tone_chk #(
  .PERIOD_W(PERIOD_W), .STEP_W(STEP_W), .VOL_W(VOL_W)
) uChk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .enBit(enBit),
  .periodVal(periodVal), .divCount(divCount),
  .stepCount(stepCount), .sampleOut(sampleOut)
);

// File: tb/pulse_tone_gen_test.sv
module pulse_tone_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic       wrCtrl = 1'b0;
  logic       wrPerLo = 1'b0;
  logic       wrPerHi = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] sampleOut;

  int checks = 0;
  int errors = 0;
  int cycleNo = 0;
  string curReq = "R7";

  // behavioural reference state
  int mMode, mDuty, mVol, mEn, mPer, mDiv, mStep, mOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_tone_gen uut (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .wrCtrl(wrCtrl), .wrPerLo(wrPerLo), .wrPerHi(wrPerHi),
    .wrData(wrData), .sampleOut(sampleOut)
  );

  task automatic modelReset();
    mMode = 0; mDuty = 0; mVol = 0; mEn = 0; mPer = 0;
    mDiv = 1; mStep = 0; mOut = 0;
  endtask

  // Advance the model by one edge with the given inputs
  task automatic modelEdge(input bit r, input bit t, input int sel, input int d);
    if (r) begin
      modelReset();
      return;
    end
    if (t) begin
      if (mDiv == 1) begin
        mDiv  = mPer + 1;
        mStep = (mStep + 1) % 16;
        mOut  = (mMode != 0 || mStep > mDuty) ? mVol : 0;
      end else begin
        mDiv = mDiv - 1;
      end
      if (mEn == 0) mOut = 0;
    end
    case (sel)
      1: begin mMode = (d >> 7) & 1; mDuty = (d >> 4) & 7; mVol = d & 15; end
      2: mPer = (mPer & 'hF00) | (d & 'hFF);
      3: begin mPer = (mPer & 'h0FF) | ((d & 15) << 8); mEn = (d >> 7) & 1; end
      default: ;
    endcase
  endtask

  // One clock: drive at negedge, compare at the following negedge
  task automatic cyc(input bit t, input int sel = 0, input int d = 0, input bit r = 0);
    rst     = r;
    tickEn  = t;
    wrCtrl  = (sel == 1);
    wrPerLo = (sel == 2);
    wrPerHi = (sel == 3);
    wrData  = 8'(d);
    modelEdge(r, t, sel, d);
    @(posedge clk);
    @(negedge clk);
    cycleNo++;
    checks++;
    if (int'(sampleOut) != mOut) begin
      errors++;
      $display("FAIL %s: cycle %0d sampleOut=%0d expected %0d", curReq, cycleNo, sampleOut, mOut);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycle %0d actual running expected finished", cycleNo);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    // R7: reset state held for a few cycles
    curReq = "R7";
    for (int i = 0; i < 4; i++) cyc(1'b1, 0, 0, 1'b1);
    ticks(5);

    // R1 R2 R3 R4: duty 3, volume 9, period 2, enabled
    curReq = "R1";
    cyc(1'b0, 1, 'h39);
    cyc(1'b0, 2, 'h02);
    cyc(1'b0, 3, 'h80);
    curReq = "R4";
    ticks(80);

    // R4: top duty threshold -> only step values above 7 sound
    curReq = "R4";
    cyc(1'b1, 1, 'h7F);
    ticks(100);

    // R4: constant-level mode ignores duty
    curReq = "R4";
    cyc(1'b1, 1, 'hF5);
    ticks(60);

    // R3: period 0 -> step every tick
    curReq = "R3";
    cyc(1'b1, 1, 'h2C);
    cyc(1'b1, 2, 'h00);
    cyc(1'b1, 3, 'h80);
    ticks(40);

    // R5: disable forces zero
    curReq = "R5";
    cyc(1'b1, 3, 'h00);
    ticks(20);
    cyc(1'b1, 3, 'h80);
    ticks(10);

    // R2: ignored bits 6..4 of the high write
    curReq = "R2";
    cyc(1'b1, 2, 'h01);
    cyc(1'b1, 3, 'hF1);
    ticks(1200);

    // R6: gaps in tickEn, writes during gaps
    curReq = "R6";
    for (int i = 0; i < 60; i++) begin
      cyc(1'b0, (i % 7 == 0) ? 1 : 0, 'h15 + i);
      cyc(1'b1);
      cyc(1'b0);
    end
    cyc(1'b0, 3, 'h00);
    cyc(1'b0);
    cyc(1'b0, 3, 'h80);
    ticks(30);

    // R8: period change mid countdown, write on reload tick
    curReq = "R8";
    cyc(1'b1, 2, 'h30);
    cyc(1'b1, 3, 'h80);
    ticks(5);
    cyc(1'b1, 2, 'h03);
    ticks(120);

    // R3: maximum period, step wraps cleanly
    curReq = "R3";
    cyc(1'b1, 1, 'h0A);
    cyc(1'b1, 2, 'hFF);
    cyc(1'b1, 3, 'h8F);
    ticks(4096 * 2 + 20);

    // Mixed random traffic
    curReq = "R4";
    cyc(1'b1, 2, 'h00);
    cyc(1'b1, 3, 'h80);
    for (int i = 0; i < 4000; i++) begin
      int sel;
      int d;
      sel = ($urandom_range(0, 9) < 2) ? int'($urandom_range(1, 3)) : 0;
      d = int'($urandom_range(0, 255));
      if (sel == 3) d = d & 'h83;
      cyc(($urandom_range(0, 3) != 0), sel, d);
    end

    // R7: reset mid-run
    curReq = "R7";
    cyc(1'b1, 0, 0, 1'b1);
    ticks(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule